// File: doc/BRIEF.md
# E1 Channel-Associated Signaling Extractor

This block sits after an E1 receive framer. It takes the serial data stream with a per-bit enable, along with frame-start and multiframe-start markers. From timeslot 16 it collects the four-bit ABCD signaling codes of the 30 voice timeslots. A signaling multiframe is 16 frames long. In frames 1 to 15, timeslot 16 carries two codes: one for voice timeslot n and one for voice timeslot n+16. Frame 0 carries the alignment pattern and the spare bits, and the block stores none of it.

For every timeslot the block keeps two banks. The latest bank holds the code exactly as extracted. The updated bank holds the code after the optional debounce. When the updated code of a timeslot changes, a sticky per-timeslot flag is set, and an interrupt follows if it is enabled. While multiframe alignment is lost, or while the receiver runs unframed, both banks and the flags stay frozen.

A host reads both banks through a one-cycle registered read port and clears flags with a write-one-to-clear mask. Storage is organised as one byte per frame index, so each timeslot-16 octet needs exactly one memory write.

Top module: `e1cas_extract`

## Requirements
- R1: Bit 1 of a timeslot is the first bit received while `bit_en` is high. In frame n (n = 1..15, counted from the `mf_start` frame as 0), bits 1-4 of timeslot 16 are stored as the code of timeslot n and bits 5-8 as the code of timeslot n+16. A code is read as {A,B,C,D} with A in bit 3.
- R2: Timeslots 0 and 16 hold no signaling and always read back 0. The contents of timeslot 16 in frame 0 and of every other timeslot have no effect on any stored code.
- R3: A value placed on `rd_ts` appears on `rd_raw` (latest code) and `rd_upd` (updated code) after the next rising clock edge.
- R4: Flag bits 0 and 16 of `chg_flags` are never set.
- R5: Without debounce, the updated code equals the latest code once the timeslot's frame has been received. With debounce, the updated code takes a newly received value only when it equals the value received in the previous multiframe; otherwise it holds its old value.
- R6: While `mf_sync` is 0 or `framed` is 0, no code in either bank changes and no flag is set.
- R7: When a timeslot's updated code changes and `chg_rpt_en` is 1, its flag is set. Flags stay set until a cycle with `clr_we` high whose `clr_mask` has a 1 in that bit position.
- R8: While `chg_rpt_en` is 0, no flag is set, although the codes still update.
- R9: `sig_irq` is high exactly when `sig_int_en` was high at the previous edge and at least one flag is set, and it changes in the same cycle as `chg_flags`.
- R10: After reset all flags are 0, `sig_irq` is 0 and every code reads 0.
- R11: Debounce applies to a timeslot only when both `deb_glb_en` and that timeslot's bit in `deb_sel` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Qualifies `rx_bit` and the timing markers for one cycle |
| rx_bit | input | 1 | Received serial data bit |
| frame_start | input | 1 | High with bit 1 of timeslot 0 of each frame |
| mf_start | input | 1 | High with `frame_start` on frame 0 of the multiframe |
| mf_sync | input | 1 | Signaling multiframe alignment is held |
| framed | input | 1 | Receiver is in framed mode |
| deb_glb_en | input | 1 | Global debounce enable |
| deb_sel | input | 32 | Per-timeslot debounce select |
| chg_rpt_en | input | 1 | Enables setting of change flags |
| sig_int_en | input | 1 | Enables the signaling interrupt |
| clr_we | input | 1 | Flag clear strobe |
| clr_mask | input | 32 | Flags to clear when `clr_we` is high |
| rd_ts | input | 5 | Timeslot to read |
| rd_raw | output | 4 | Latest extracted code of `rd_ts` |
| rd_upd | output | 4 | Updated (debounced) code of `rd_ts` |
| chg_flags | output | 32 | Sticky change-of-signaling flags |
| sig_irq | output | 1 | Signaling interrupt |

## Verification
A wrong bit position or frame count inside the extractor puts codes into the wrong timeslot or the wrong nibble. That fault is visible on `rd_raw` one read cycle after the multiframe that carried them. A faulty debounce comparison or a stale prefetch register shows up as an `rd_upd` value that moves one multiframe too early, or not at all. Flag and freeze faults appear on `chg_flags` and `sig_irq` in the cycle after the offending octet. The directed scenarios therefore compare every timeslot's two codes and the full flag word after each multiframe, against a model driven only by the requirements.

// File: rtl/e1cas_pkg.sv
package e1cas_pkg;
  localparam int TS_BITS    = 8;
  localparam int NUM_TS     = 32;
  localparam int MF_FRAMES  = 16;
  localparam int CAS_TS     = 16;
  localparam int CODE_W     = 4;
  localparam int FRAME_BITS = TS_BITS * NUM_TS;
  localparam int POS_W      = $clog2(FRAME_BITS);
  localparam int FIDX_W     = $clog2(MF_FRAMES);
  localparam int TS_W       = $clog2(NUM_TS);
  localparam int CAS_FIRST  = CAS_TS * TS_BITS;
  localparam int CAS_LAST   = CAS_FIRST + TS_BITS - 1;

  // timeslots that may carry a change flag
  function automatic logic [NUM_TS-1:0] sig_ts_mask();
    logic [NUM_TS-1:0] m;
    m = '1;
    m[0] = 1'b0;
    m[CAS_TS] = 1'b0;
    return m;
  endfunction
endpackage

// File: rtl/e1cas_framecnt.sv
module e1cas_framecnt
  import e1cas_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              rx_bit,
  input  logic              frame_start,
  input  logic              mf_start,
  output logic              pf_req,
  output logic [FIDX_W-1:0] pf_fidx,
  output logic              oct_vld,
  output logic [TS_BITS-1:0] oct_data,
  output logic [FIDX_W-1:0] oct_fidx
);
  localparam logic [POS_W-1:0] P_FIRST = POS_W'(CAS_FIRST);
  localparam logic [POS_W-1:0] P_LAST  = POS_W'(CAS_LAST);
  localparam logic [POS_W-1:0] P_END   = POS_W'(FRAME_BITS - 1);

  logic [POS_W-1:0]   pos_q, cur_pos;
  logic [FIDX_W-1:0]  fidx_q, cur_f;
  logic [TS_BITS-1:0] sh_q;

  always_comb begin
    cur_pos = frame_start ? '0 : pos_q;
    if (frame_start) cur_f = mf_start ? '0 : fidx_q + 1'b1;
    else             cur_f = fidx_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q    <= '0;
      fidx_q   <= '0;
      sh_q     <= '0;
      pf_req   <= 1'b0;
      pf_fidx  <= '0;
      oct_vld  <= 1'b0;
      oct_data <= '0;
      oct_fidx <= '0;
    end else begin
      pf_req  <= 1'b0;
      oct_vld <= 1'b0;
      if (bit_en) begin
        pos_q  <= (cur_pos == P_END) ? '0 : cur_pos + 1'b1;
        fidx_q <= cur_f;
        if (cur_pos >= P_FIRST && cur_pos <= P_LAST)
          sh_q <= {sh_q[TS_BITS-2:0], rx_bit};
        if (cur_pos == P_FIRST) begin
          pf_req  <= 1'b1;
          pf_fidx <= cur_f;
        end
        if (cur_pos == P_LAST) begin
          oct_vld  <= 1'b1;
          oct_data <= {sh_q[TS_BITS-2:0], rx_bit};
          oct_fidx <= cur_f;
        end
      end
    end
  end
endmodule

// File: rtl/e1cas_sigstore.sv
module e1cas_sigstore
  import e1cas_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               pf_req,
  input  logic [FIDX_W-1:0]  pf_fidx,
  input  logic               oct_vld,
  input  logic [TS_BITS-1:0] oct_data,
  input  logic [FIDX_W-1:0]  oct_fidx,
  input  logic               sync_ok,
  input  logic               deb_glb_en,
  input  logic [NUM_TS-1:0]  deb_sel,
  input  logic [TS_W-1:0]    host_ts,
  output logic [CODE_W-1:0]  host_raw,
  output logic [CODE_W-1:0]  host_upd,
  output logic [NUM_TS-1:0]  chg_vec
);
  // one byte per frame index: upper code = timeslot n, lower = n+16
  logic [TS_BITS-1:0] raw_mem [MF_FRAMES];
  logic [TS_BITS-1:0] upd_mem [MF_FRAMES];
  logic [MF_FRAMES-1:0] vld_q;

  logic [TS_BITS-1:0] pr_raw_m, pr_upd_m, h_raw_m, h_upd_m;
  logic               pr_vld_q, h_vld_q, h_lo_q;
  logic [TS_BITS-1:0] prv_raw, prv_upd, upd_byte;
  logic               wr_en;

  always_ff @(posedge clk) begin
    if (pf_req) begin
      pr_raw_m <= raw_mem[pf_fidx];
      pr_upd_m <= upd_mem[pf_fidx];
    end
    h_raw_m <= raw_mem[host_ts[FIDX_W-1:0]];
    h_upd_m <= upd_mem[host_ts[FIDX_W-1:0]];
    if (wr_en) begin
      raw_mem[oct_fidx] <= oct_data;
      upd_mem[oct_fidx] <= upd_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q    <= '0;
      pr_vld_q <= 1'b0;
      h_vld_q  <= 1'b0;
      h_lo_q   <= 1'b0;
    end else begin
      if (wr_en) vld_q[oct_fidx] <= 1'b1;
      if (pf_req) pr_vld_q <= vld_q[pf_fidx];
      h_vld_q <= vld_q[host_ts[FIDX_W-1:0]];
      h_lo_q  <= host_ts[TS_W-1];
    end
  end

  assign prv_raw = pr_vld_q ? pr_raw_m : '0;
  assign prv_upd = pr_vld_q ? pr_upd_m : '0;
  assign wr_en   = oct_vld && sync_ok && (oct_fidx != '0);

  logic [CODE_W-1:0] new_c [2];
  logic [CODE_W-1:0] pr_c  [2];
  logic [CODE_W-1:0] pu_c  [2];
  logic [CODE_W-1:0] up_c  [2];
  logic [TS_W-1:0]   ts_c  [2];
  logic              deb_c [2];

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign new_c[h] = oct_data[h*CODE_W +: CODE_W];
    assign pr_c[h]  = prv_raw[h*CODE_W +: CODE_W];
    assign pu_c[h]  = prv_upd[h*CODE_W +: CODE_W];
    assign ts_c[h]  = {((h == 0) ? 1'b1 : 1'b0), oct_fidx};
    assign deb_c[h] = deb_glb_en & deb_sel[ts_c[h]];
    assign up_c[h]  = (!deb_c[h] || new_c[h] == pr_c[h]) ? new_c[h] : pu_c[h];
  end

  assign upd_byte = {up_c[1], up_c[0]};

  always_comb begin
    chg_vec = '0;
    if (wr_en)
      for (int h = 0; h < 2; h++)
        if (up_c[h] != pu_c[h]) chg_vec[ts_c[h]] = 1'b1;
  end

  always_comb begin
    if (!h_vld_q) begin
      host_raw = '0;
      host_upd = '0;
    end else if (h_lo_q) begin
      host_raw = h_raw_m[CODE_W-1:0];
      host_upd = h_upd_m[CODE_W-1:0];
    end else begin
      host_raw = h_raw_m[TS_BITS-1 -: CODE_W];
      host_upd = h_upd_m[TS_BITS-1 -: CODE_W];
    end
  end
endmodule

// File: rtl/e1cas_cosflags.sv
module e1cas_cosflags
  import e1cas_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_TS-1:0] chg_vec,
  input  logic              chg_rpt_en,
  input  logic              sig_int_en,
  input  logic              clr_we,
  input  logic [NUM_TS-1:0] clr_mask,
  output logic [NUM_TS-1:0] flags_q,
  output logic              irq_q
);
  localparam logic [NUM_TS-1:0] SIG_MASK = sig_ts_mask();
  logic [NUM_TS-1:0] flags_n;

  always_comb begin
    flags_n = flags_q;
    if (clr_we) flags_n = flags_n & ~clr_mask;
    if (chg_rpt_en) flags_n = flags_n | (chg_vec & SIG_MASK);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_n;
      irq_q   <= sig_int_en && (|flags_n);
    end
  end
endmodule

// File: rtl/e1cas_extract.sv
module e1cas_extract
  import e1cas_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              rx_bit,
  input  logic              frame_start,
  input  logic              mf_start,
  input  logic              mf_sync,
  input  logic              framed,
  input  logic              deb_glb_en,
  input  logic [NUM_TS-1:0] deb_sel,
  input  logic              chg_rpt_en,
  input  logic              sig_int_en,
  input  logic              clr_we,
  input  logic [NUM_TS-1:0] clr_mask,
  input  logic [TS_W-1:0]   rd_ts,
  output logic [CODE_W-1:0] rd_raw,
  output logic [CODE_W-1:0] rd_upd,
  output logic [NUM_TS-1:0] chg_flags,
  output logic              sig_irq
);
  logic               pf_req, oct_vld;
  logic [FIDX_W-1:0]  pf_fidx, oct_fidx;
  logic [TS_BITS-1:0] oct_data;
  logic [NUM_TS-1:0]  chg_vec;

  e1cas_framecnt u_cnt (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit),
    .frame_start(frame_start), .mf_start(mf_start),
    .pf_req(pf_req), .pf_fidx(pf_fidx),
    .oct_vld(oct_vld), .oct_data(oct_data), .oct_fidx(oct_fidx)
  );

  e1cas_sigstore u_store (
    .clk(clk), .rst(rst), .pf_req(pf_req), .pf_fidx(pf_fidx),
    .oct_vld(oct_vld), .oct_data(oct_data), .oct_fidx(oct_fidx),
    .sync_ok(mf_sync && framed), .deb_glb_en(deb_glb_en), .deb_sel(deb_sel),
    .host_ts(rd_ts), .host_raw(rd_raw), .host_upd(rd_upd), .chg_vec(chg_vec)
  );

  e1cas_cosflags u_flags (
    .clk(clk), .rst(rst), .chg_vec(chg_vec), .chg_rpt_en(chg_rpt_en),
    .sig_int_en(sig_int_en), .clr_we(clr_we), .clr_mask(clr_mask),
    .flags_q(chg_flags), .irq_q(sig_irq)
  );
endmodule

// File: rtl/e1cas_extract_chk.sv
module e1cas_extract_chk
  import e1cas_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              mf_sync,
  input logic              framed,
  input logic              chg_rpt_en,
  input logic              sig_int_en,
  input logic              clr_we,
  input logic [NUM_TS-1:0] chg_flags,
  input logic              sig_irq
);
  assert_no_sig_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (chg_flags[0] == 1'b0) && (chg_flags[CAS_TS] == 1'b0));

  assert_freeze_R6: assert property (@(posedge clk) disable iff (rst)
    (!mf_sync || !framed) |=> ((chg_flags & ~$past(chg_flags)) == '0));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    !clr_we |=> ((~chg_flags & $past(chg_flags)) == '0));

  assert_rpt_off_R8: assert property (@(posedge clk) disable iff (rst)
    !chg_rpt_en |=> ((chg_flags & ~$past(chg_flags)) == '0));

  assert_irq_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (chg_flags == '0) |-> !sig_irq);

  assert_irq_en_R9: assert property (@(posedge clk) disable iff (rst)
    sig_irq |-> $past(sig_int_en));

  assert_reset_R10: assert property (@(posedge clk)
    rst |=> ((chg_flags == '0) && !sig_irq));
endmodule

bind e1cas_extract e1cas_extract_chk u_chk (
  .clk(clk), .rst(rst), .mf_sync(mf_sync), .framed(framed),
  .chg_rpt_en(chg_rpt_en), .sig_int_en(sig_int_en), .clr_we(clr_we),
  .chg_flags(chg_flags), .sig_irq(sig_irq)
);

// File: tb/e1cas_extract_tb.sv
module e1cas_extract_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 0, rx_bit = 0, frame_start = 0, mf_start = 0;
  logic mf_sync = 1, framed = 1, deb_glb_en = 0, chg_rpt_en = 1, sig_int_en = 0, clr_we = 0;
  logic [31:0] deb_sel = '0, clr_mask = '0;
  logic [4:0]  rd_ts = '0;
  logic [3:0]  rd_raw, rd_upd;
  logic [31:0] chg_flags;
  logic        sig_irq;

  int n_chk = 0, n_fail = 0;
  logic [3:0]  tx [32];
  logic [3:0]  exp_raw [32];
  logic [3:0]  exp_upd [32];
  logic [31:0] exp_flags = '0;

  always #2 clk = ~clk;

  e1cas_extract u_dut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .rx_bit(rx_bit),
    .frame_start(frame_start), .mf_start(mf_start), .mf_sync(mf_sync),
    .framed(framed), .deb_glb_en(deb_glb_en), .deb_sel(deb_sel),
    .chg_rpt_en(chg_rpt_en), .sig_int_en(sig_int_en), .clr_we(clr_we),
    .clr_mask(clr_mask), .rd_ts(rd_ts), .rd_raw(rd_raw), .rd_upd(rd_upd),
    .chg_flags(chg_flags), .sig_irq(sig_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] octet(input int f, input int ts);
    if (ts == 16) return (f == 0) ? 8'h0B : {tx[f], tx[f+16]};
    return 8'((f * 37 + ts * 11) ^ 8'h5A);
  endfunction

  // stream one 16-frame multiframe carrying tx[], then update the model
  task automatic send_mf();
    for (int f = 0; f < 16; f++)
      for (int b = 0; b < 256; b++) begin
        @(negedge clk);
        bit_en      = 1'b1;
        frame_start = (b == 0);
        mf_start    = (b == 0) && (f == 0);
        rx_bit      = octet(f, b / 8)[7 - (b % 8)];
      end
    @(negedge clk);
    bit_en = 0; frame_start = 0; mf_start = 0;
    repeat (3) @(negedge clk);
    if (mf_sync && framed)
      for (int ts = 1; ts < 32; ts++) begin
        logic [3:0] u;
        if (ts == 16) continue;
        u = (!(deb_glb_en && deb_sel[ts]) || tx[ts] == exp_raw[ts]) ? tx[ts] : exp_upd[ts];
        if (u != exp_upd[ts] && chg_rpt_en) exp_flags[ts] = 1'b1;
        exp_upd[ts] = u;
        exp_raw[ts] = tx[ts];
      end
  endtask

  task automatic check_all(input string req);
    for (int ts = 0; ts < 32; ts++) begin
      @(negedge clk);
      rd_ts = 5'(ts);
      @(negedge clk);
      chk({req, " latest code"}, {28'd0, rd_raw}, {28'd0, exp_raw[ts]});
      chk({req, " updated code"}, {28'd0, rd_upd}, {28'd0, exp_upd[ts]});
    end
    chk({req, " R7 flags"}, chg_flags, exp_flags);
    chk({req, " R9 irq"}, {31'd0, sig_irq}, {31'd0, sig_int_en && (exp_flags != 0)});
  endtask

  task automatic t_reset();
    chk("R10 flags", chg_flags, '0);
    chk("R10 irq", {31'd0, sig_irq}, 0);
    check_all("R10/R3");
  endtask

  task automatic t_basic();
    for (int i = 0; i < 32; i++) tx[i] = 4'((i * 5 + 3) & 15);
    send_mf();
    check_all("R1/R2/R5");
    chk("R4 no flag ts0/ts16", {30'd0, chg_flags[16], chg_flags[0]}, 0);
    chk("R9 irq disabled", {31'd0, sig_irq}, 0);
  endtask

  task automatic t_clear();
    @(negedge clk); clr_we = 1; clr_mask = 32'h0002_00F0;
    @(negedge clk); clr_we = 0; clr_mask = '0;
    exp_flags &= ~32'h0002_00F0;
    @(negedge clk);
    chk("R7 w1c partial", chg_flags, exp_flags);
    sig_int_en = 1;
    @(negedge clk); @(negedge clk);
    chk("R9 irq on", {31'd0, sig_irq}, {31'd0, exp_flags != 0});
    @(negedge clk); clr_we = 1; clr_mask = '1;
    @(negedge clk); clr_we = 0; clr_mask = '0;
    exp_flags = '0;
    @(negedge clk);
    chk("R7 w1c all", chg_flags, 0);
    chk("R9 irq off", {31'd0, sig_irq}, 0);
  endtask

  task automatic t_debounce();
    deb_glb_en = 1; deb_sel = 32'h001E_00FE;
    for (int i = 0; i < 32; i++) tx[i] = 4'((i * 3 + 9) & 15);
    send_mf();
    check_all("R5 debounce first");
    send_mf();
    check_all("R5 debounce second");
    deb_glb_en = 0;
    for (int i = 0; i < 32; i++) tx[i] = 4'((i * 7 + 1) & 15);
    send_mf();
    check_all("R11 global off");
  endtask

  task automatic t_freeze();
    for (int i = 0; i < 32; i++) tx[i] = 4'(~i);
    mf_sync = 0;
    send_mf();
    check_all("R6 out of sync");
    mf_sync = 1; framed = 0;
    send_mf();
    check_all("R6 unframed");
    framed = 1;
  endtask

  task automatic t_rpt_off();
    @(negedge clk); clr_we = 1; clr_mask = '1;
    @(negedge clk); clr_we = 0; clr_mask = '0;
    exp_flags = '0;
    chg_rpt_en = 0;
    for (int i = 0; i < 32; i++) tx[i] = 4'((i * 11 + 6) & 15);
    send_mf();
    check_all("R8 reporting off");
    chg_rpt_en = 1;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin exp_raw[i] = 0; exp_upd[i] = 0; tx[i] = 0; end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_clear();
    t_debounce();
    t_freeze();
    t_rpt_off();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule